// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block is the command front end of a serial flash device, limited to the path that changes the status register. It oversamples a serial bus made of chip select, serial clock and serial data in, using a system clock. Within each chip-select-low frame it shifts in an opcode and, when one is expected, a data byte. Only when chip select rises does it decide what the frame was. If the frame is valid, it updates the status register.

A change to the protection bits needs two frames back to back. The first is an arming frame, which may be either the status-enable opcode or the write-enable opcode. The second is a write-status frame carrying the new byte. The write-protect pin and the sticky lock bit then decide whether the new value is taken. While the pin is low, the lock can be set but never cleared. The current status byte and the protection fields are driven out continuously.

Top module: `sfl_wrsr_guard`

## Requirements
- R1: After reset, `status_q` reads 0x1C. The layout is: bit 0 busy (always 0), bit 1 write-enable latch, bits 4:2 the three block-protect bits (bit 2 is the lowest), bits 6:5 reserved (always 0), and bit 7 the lock bit. After reset the protect bits are 111, and the lock bit and the write-enable latch are 0.
- R2: Serial data is taken most significant bit first, on rising serial-clock edges while chip select is low. A frame acts only after chip select rises. The status stays unchanged while chip select is still low, even after a complete frame.
- R3: A frame of exactly 8 clocks carrying 0x06 arms the block and sets the write-enable latch. A frame of exactly 8 clocks carrying 0x50 arms the block and leaves the latch unchanged.
- R4: A write-status frame is exactly 16 clocks: opcode 0x01, then a data byte. If it comes in the frame right after an arming frame and the write-protect pin is high, the lock bit takes data bit 7 and the protect bits take data bits 4:2. Data bits 6:5 and 1:0 are ignored.
- R5: Arming is one-shot. Any other frame between the arming frame and the write-status frame cancels it, and that write-status frame then leaves the protection bits unchanged.
- R6: A frame whose clock count does not match its opcode (write-status with 15 or 17 clocks, or an arming opcode with 9 clocks) is discarded. It cancels the arm and leaves the write-enable latch unchanged.
- R7: Every well-formed write-status frame clears the arm and the write-enable latch, whether or not it was applied. A repeat write-status with no new arming frame has no effect on the protection bits.
- R8: If the write-protect pin is low and the lock bit is 1, a write-status leaves all protection bits unchanged.
- R9: If the write-protect pin is low and the lock bit is 0, a write-status applies in full, including setting the lock bit in the same frame.
- R10: Both serial-clock polarities are accepted: idle low (mode 0) and idle high (mode 3).
- R11: The write-protect level that counts is the one present when chip select rises, not its level earlier in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low; one frame per low period |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin; low enables lock enforcement |
| status_q | output | 8 | Current status byte |
| prot_bp | output | 3 | Block-protect bits |
| prot_lock | output | 1 | Lock bit |

## Verification
The main write path is swept over every pairing of write-protect level and starting lock state. Each of the 16 new lock/protect combinations is tried, with the ignored data bits filled with changing junk. The two arming opcodes and the two clock polarities alternate across the sweep, so a swapped opcode, a wrong bit order, a stuck polarity or a lock rule that forgets either input shows up as a mismatch.

Directed sequences then cover the following:
- an arm cancelled by an unrelated frame;
- frames one clock short or one clock long;
- a repeated write with no new arm;
- a complete frame held open with chip select low;
- a write-protect level that changes inside a frame.

These separate commit-at-chip-select-rise behaviour from commit-on-count behaviour.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_ARM_SR = 8'h50;
    localparam logic [OPC_W-1:0] OPC_WR_EN  = 8'h06;
    localparam logic [OPC_W-1:0] OPC_WR_SR  = 8'h01;

    localparam int ST_BUSY   = 0;
    localparam int ST_WEL    = 1;
    localparam int ST_BP_LO  = 2;
    localparam int ST_LOCK   = 7;

    typedef enum logic [1:0] {
        FK_OTHER = 2'd0,
        FK_ARM   = 2'd1,
        FK_WREN  = 2'd2,
        FK_WRSR  = 2'd3
    } frame_kind_e;

    typedef struct packed {
        logic       lock;
        logic [2:0] bp;
    } prot_t;

    localparam prot_t PROT_RST = '{lock: 1'b0, bp: 3'b111};

    function automatic frame_kind_e classify(input logic short_len,
                                             input logic long_len,
                                             input logic [OPC_W-1:0] op_short,
                                             input logic [OPC_W-1:0] op_long);
        frame_kind_e k;
        k = FK_OTHER;
        if (short_len && op_short == OPC_ARM_SR)
            k = FK_ARM;
        else if (short_len && op_short == OPC_WR_EN)
            k = FK_WREN;
        else if (long_len && op_long == OPC_WR_SR)
            k = FK_WRSR;
        return k;
    endfunction

    function automatic prot_t data_to_prot(input logic [7:0] d);
        prot_t p;
        p.lock = d[ST_LOCK];
        p.bp   = d[ST_BP_LO +: 3];
        return p;
    endfunction

    function automatic logic write_allowed(input logic wp_n_lvl, input logic lock);
        return wp_n_lvl | ~lock;
    endfunction

    function automatic logic [7:0] pack_status(input prot_t p, input logic wel);
        logic [7:0] s;
        s                = '0;
        s[ST_BUSY]       = 1'b0;
        s[ST_WEL]        = wel;
        s[ST_BP_LO +: 3] = p.bp;
        s[ST_LOCK]       = p.lock;
        return s;
    endfunction

endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++)
                chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sfl_frame_rx.sv
module sfl_frame_rx
    import sfl_pkg::*;
#(
    parameter int FRAME_MAX = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n_s,
    input  logic        sck_s,
    input  logic        si_s,
    output logic        done,
    output frame_kind_e kind,
    output logic [7:0]  data
);

    localparam int                CNT_W   = $clog2(FRAME_MAX + 2);
    localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0]  LEN_SHORT = CNT_W'(OPC_W);
    localparam logic [CNT_W-1:0]  LEN_LONG  = CNT_W'(FRAME_MAX);

    logic                 sck_d, cs_n_d;
    logic                 sck_rise, cs_rise, cs_fall;
    logic [CNT_W-1:0]     cnt;
    logic [FRAME_MAX-1:0] sh;

    assign sck_rise = sck_s & ~sck_d;
    assign cs_rise  = cs_n_s & ~cs_n_d;
    assign cs_fall  = ~cs_n_s & cs_n_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d  <= 1'b1;
            cs_n_d <= 1'b1;
        end else begin
            sck_d  <= sck_s;
            cs_n_d <= cs_n_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sh  <= '0;
        end else if (cs_fall) begin
            cnt <= '0;
            sh  <= '0;
        end else if (!cs_n_s && sck_rise) begin
            sh <= {sh[FRAME_MAX-2:0], si_s};
            if (cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            kind <= FK_OTHER;
            data <= '0;
        end else begin
            done <= cs_rise;
            if (cs_rise) begin
                kind <= classify(cnt == LEN_SHORT, cnt == LEN_LONG,
                                 sh[OPC_W-1:0], sh[FRAME_MAX-1 -: OPC_W]);
                data <= sh[7:0];
            end
        end
    end

    // R2: a frame result is produced for every chip-select rise and only then
    p_done_on_cs_rise_r2: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> done);
    p_no_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !cs_rise |=> !done);
    // R2: nothing is counted while chip select is high
    p_count_frozen_idle_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> $stable(cnt));

endmodule

// File: rtl/sfl_status_core.sv
module sfl_status_core
    import sfl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        done,
    input  frame_kind_e kind,
    input  logic [7:0]  data,
    input  logic        wp_n_s,
    output prot_t       prot,
    output logic        wel
);

    logic arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot <= PROT_RST;
            wel  <= 1'b0;
            arm  <= 1'b0;
        end else if (done) begin
            unique case (kind)
                FK_ARM: begin
                    arm <= 1'b1;
                end
                FK_WREN: begin
                    arm <= 1'b1;
                    wel <= 1'b1;
                end
                FK_WRSR: begin
                    if (arm && write_allowed(wp_n_s, prot.lock))
                        prot <= data_to_prot(data);
                    arm <= 1'b0;
                    wel <= 1'b0;
                end
                default: begin
                    arm <= 1'b0;
                end
            endcase
        end
    end

    // R2: protection bits move only on a completed frame
    p_hold_between_frames_r2: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(prot));
    // R8: pin low with lock set blocks every write
    p_locked_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (done && kind == FK_WRSR && !wp_n_s && prot.lock) |=> $stable(prot));
    // R8: lock cannot drop while the pin is low
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (!wp_n_s && prot.lock) |=> prot.lock);
    // R5: any non-arming frame leaves the block unarmed
    p_arm_one_shot_r5: assert property (@(posedge clk) disable iff (rst)
        (done && (kind == FK_OTHER || kind == FK_WRSR)) |=> !arm);
    // R7: a write-status frame always clears the latch
    p_wrsr_clears_wel_r7: assert property (@(posedge clk) disable iff (rst)
        (done && kind == FK_WRSR) |=> !wel);

endmodule

// File: rtl/sfl_wrsr_guard.sv
module sfl_wrsr_guard
    import sfl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_MAX   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_si,
    input  logic       wp_n,
    output logic [7:0] status_q,
    output logic [2:0] prot_bp,
    output logic       prot_lock
);

    localparam int          SYNC_W   = 4;
    localparam logic [3:0]  SYNC_RST = 4'b1011;

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic              cs_n_s, sck_s, si_s, wp_n_s;
    logic              done;
    frame_kind_e       kind;
    logic [7:0]        data;
    prot_t             prot;
    logic              wel;

    assign raw_in = {wp_n, spi_si, spi_sck, spi_cs_n};
    assign {wp_n_s, si_s, sck_s, cs_n_s} = sync_out;

    sfl_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_out)
    );

    sfl_frame_rx #(
        .FRAME_MAX (FRAME_MAX)
    ) u_rx (
        .clk    (clk),
        .rst    (rst),
        .cs_n_s (cs_n_s),
        .sck_s  (sck_s),
        .si_s   (si_s),
        .done   (done),
        .kind   (kind),
        .data   (data)
    );

    sfl_status_core u_core (
        .clk    (clk),
        .rst    (rst),
        .done   (done),
        .kind   (kind),
        .data   (data),
        .wp_n_s (wp_n_s),
        .prot   (prot),
        .wel    (wel)
    );

    assign status_q  = pack_status(prot, wel);
    assign prot_bp   = prot.bp;
    assign prot_lock = prot.lock;

endmodule

// File: tb/tb_sfl_wrsr_guard.sv
module tb_sfl_wrsr_guard;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;
    localparam int SETTLE     = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       spi_cs_n, spi_sck, spi_si, wp_n;
    logic [7:0] status_q;
    logic [2:0] prot_bp;
    logic       prot_lock;

    int checks = 0;
    int errors = 0;

    logic [2:0] m_bp;
    logic       m_bpl, m_wel, m_arm;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfl_wrsr_guard dut (
        .clk (clk), .rst (rst),
        .spi_cs_n (spi_cs_n), .spi_sck (spi_sck), .spi_si (spi_si),
        .wp_n (wp_n),
        .status_q (status_q), .prot_bp (prot_bp), .prot_lock (prot_lock)
    );

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h exp %02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {m_bpl, 2'b00, m_bp, m_wel, 1'b0};
    endfunction

    task automatic chk_all(input string tag);
        chk(tag, status_q, exp_status());
        chk(tag, {5'd0, prot_bp}, {5'd0, m_bp});
        chk(tag, {7'd0, prot_lock}, {7'd0, m_bpl});
    endtask

    task automatic f_open(input bit mode3);
        spi_sck = mode3;
        clks(2);
        spi_cs_n = 1'b0;
        clks(HALF);
    endtask

    task automatic f_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            spi_sck = 1'b0;
            spi_si  = bits[i];
            clks(HALF);
            spi_sck = 1'b1;
            clks(HALF);
        end
    endtask

    task automatic f_close(input bit mode3);
        if (!mode3) begin
            spi_sck = 1'b0;
            clks(HALF);
        end
        spi_cs_n = 1'b1;
        clks(SETTLE);
    endtask

    task automatic send(input logic [31:0] bits, input int n, input bit mode3);
        f_open(mode3);
        f_bits(bits, n);
        f_close(mode3);
    endtask

    task automatic cmd_arm(input logic [7:0] op, input bit mode3);
        send({24'd0, op}, 8, mode3);
        m_arm = 1'b1;
        if (op == 8'h06) m_wel = 1'b1;
    endtask

    task automatic cmd_wrsr(input logic [7:0] d, input bit mode3);
        send({16'd0, 8'h01, d}, 16, mode3);
        if (m_arm && (wp_n || !m_bpl)) begin
            m_bpl = d[7];
            m_bp  = d[4:2];
        end
        m_arm = 1'b0;
        m_wel = 1'b0;
    endtask

    task automatic cmd_other(input logic [31:0] bits, input int n, input bit mode3);
        send(bits, n, mode3);
        m_arm = 1'b0;
    endtask

    initial begin
        clks(200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; spi_cs_n = 1'b1; spi_sck = 1'b0; spi_si = 1'b0; wp_n = 1'b1;
        m_bp = 3'b111; m_bpl = 1'b0; m_wel = 1'b0; m_arm = 1'b0;
        clks(5);
        rst = 1'b0;
        clks(5);
        chk("R1 reset status", status_q, 8'h1C);
        chk_all("R1 reset fields");

        // Main sweep: pin level x starting lock x 16 new lock/protect values
        for (int wpi = 0; wpi < 2; wpi++) begin
            for (int ib = 0; ib < 2; ib++) begin
                for (int n = 0; n < 16; n++) begin
                    bit         m3;
                    logic [7:0] op, d;
                    m3 = n[0] ^ wpi[0];
                    wp_n = 1'b1;
                    clks(4);
                    cmd_arm(8'h50, m3);
                    cmd_wrsr({ib[0], 2'b11, 3'(n), 2'b10}, m3);
                    wp_n = wpi[0];
                    clks(4);
                    op = n[1] ? 8'h06 : 8'h50;
                    cmd_arm(op, m3);
                    chk(n[1] ? "R3 wren sets latch" : "R3 arm keeps latch", status_q, exp_status());
                    d = {n[3], n[1:0], n[2:0] ^ 3'b101, n[3:2]};
                    cmd_wrsr(d, m3);
                    if (wpi == 0 && ib == 1)      chk_all("R8 locked pin low");
                    else if (wpi == 0)            chk_all("R9 pin low lock clear");
                    else if (m3)                  chk_all("R10 mode3 write");
                    else                          chk_all("R4 pin high write");
                end
            end
        end

        // R4: pin high lets a set lock be cleared; reserved bits stay zero
        wp_n = 1'b1; clks(4);
        cmd_arm(8'h06, 1'b0); cmd_wrsr(8'hFF, 1'b0);
        chk("R4 all ones", status_q, 8'h9C);
        cmd_arm(8'h06, 1'b1); cmd_wrsr(8'h00, 1'b1);
        chk_all("R4 clear lock pin high");

        // R5: intervening frame cancels arm; latch kept
        cmd_arm(8'h06, 1'b0);
        cmd_other({24'd0, 8'h05}, 8, 1'b0);
        chk_all("R5 after intervening frame");
        cmd_wrsr(8'h9C, 1'b0);
        chk_all("R5 unarmed write ignored");

        // R6: wrong clock counts
        cmd_arm(8'h06, 1'b0);
        cmd_other({17'd0, 8'h01, 7'h4E}, 15, 1'b0);
        chk_all("R6 short write discarded");
        cmd_wrsr(8'h9C, 1'b0);
        chk_all("R6 arm lost after short");
        cmd_arm(8'h50, 1'b1);
        cmd_other({15'd0, 8'h01, 8'h9C, 1'b0}, 17, 1'b1);
        chk_all("R6 long write discarded");
        cmd_wrsr(8'h9C, 1'b1);
        chk_all("R6 arm lost after long");
        cmd_other({23'd0, 8'h06, 1'b0}, 9, 1'b0);
        chk_all("R6 nine-clock arm no latch");
        cmd_wrsr(8'h9C, 1'b0);
        chk_all("R6 nine-clock arm not armed");

        // R7: repeat write without re-arming
        cmd_arm(8'h06, 1'b0); cmd_wrsr(8'h14, 1'b0);
        chk_all("R7 first write applied");
        cmd_wrsr(8'h88, 1'b0);
        chk_all("R7 second write ignored");

        // R2: complete frame held open does nothing until chip select rises
        cmd_arm(8'h50, 1'b0);
        f_open(1'b0);
        f_bits({16'd0, 8'h01, 8'h0C}, 16);
        clks(SETTLE);
        chk_all("R2 held frame no change");
        f_close(1'b0);
        m_bp = 3'b011; m_bpl = 1'b0; m_arm = 1'b0; m_wel = 1'b0;
        chk_all("R2 commit on cs rise");

        // R11: pin level at chip-select rise decides
        wp_n = 1'b1; clks(4);
        cmd_arm(8'h50, 1'b0); cmd_wrsr(8'h84, 1'b0);
        wp_n = 1'b0; clks(4);
        cmd_arm(8'h06, 1'b0);
        f_open(1'b0);
        f_bits({16'd0, 8'h01, 8'h1C}, 16);
        wp_n = 1'b1;
        clks(6);
        f_close(1'b0);
        m_bp = 3'b111; m_bpl = 1'b0; m_arm = 1'b0; m_wel = 1'b0;
        chk_all("R11 pin raised before cs rise");
        cmd_arm(8'h50, 1'b0); cmd_wrsr(8'h80, 1'b0);
        cmd_arm(8'h06, 1'b1);
        f_open(1'b1);
        f_bits({16'd0, 8'h01, 8'h00}, 16);
        wp_n = 1'b0;
        clks(6);
        f_close(1'b1);
        m_arm = 1'b0; m_wel = 1'b0;
        chk_all("R11 pin dropped before cs rise");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule